// File: doc/BRIEF.md
# Serial tuner frequency word loader

This block turns a requested receive frequency into the 24-bit control word that a frequency-synthesizer tuner expects, then loads that word over a three-wire serial link (data, clock, enable). The frequency arrives in units of 62.5 Hz. The block adds a fixed 10.7 MHz intermediate-frequency offset (171200 units), then divides the sum by 400 to get a divider count in 25 kHz steps. It then ORs that count into a word whose top bits select FM mode and the 25 kHz reference step.

A single-cycle `start` strobe captures the frequency. A sequential restoring divider runs first. After it, the word is shifted out least significant bit first. Each bit has three timed phases of equal length: a setup phase, a clock-high phase and a clock-low hold phase. The phase length comes from the system clock frequency parameter and a 2 µs phase time. Enable stays high across the whole word, and all three pins return low once the word has been sent. `busy` covers the whole operation, and `done` marks its end with a single-cycle pulse.

Top module: `tuner_word_loader`

## Requirements
- R1: While reset is high and on the first cycle after its release, `ser_data`, `ser_clk`, `ser_en`, `busy` and `done` are all 0.
- R2: Bits 19:0 of the transmitted word equal bits 19:0 of floor((freq + 171200) / 400), rounded down, with any remainder discarded.
- R3: Bit 23 of the transmitted word is 1 (FM mode), bit 22 is 0, and bits 21:20 carry step code 2 (25 kHz). The divider count is ORed into the word without masking, so count bits 21:20 that are set also appear in word bits 21:20.
- R4: Exactly 24 bits are sent per word, bit 0 first and bit 23 last. Each bit is the value of `ser_data` at the rising edge of `ser_clk`.
- R5: With P = CLK_HZ × 2 µs in cycles, the first rising edge of `ser_clk` comes P cycles after `ser_en` rises, and `ser_data` is stable for at least those P cycles. Every high phase of `ser_clk` lasts exactly P cycles.
- R6: Between successive bits, `ser_clk` is low for exactly 2P cycles: the hold phase of one bit followed by the setup phase of the next. `ser_data` does not change while `ser_clk` is high. `ser_clk` is never high while `ser_en` is low.
- R7: P cycles after the last falling edge of `ser_clk`, `ser_en` goes low, and from then on all three pins stay low until the next accepted start.
- R8: `busy` is 1 from the cycle after an accepted `start` until the cycle in which the pins return low; in that cycle it is 0. An idle block accepts `start` in any cycle, including the cycle right after `done`.
- R9: `done` is high for exactly one cycle, the first cycle in which all pins are low after a word.
- R10: A `start` that arrives while `busy` is 1 has no effect. The word in flight is unchanged and no second word is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to load `freq` |
| freq | input | FREQ_W | Requested frequency in 62.5 Hz units |
| busy | output | 1 | Conversion or transmission in progress |
| done | output | 1 | One-cycle pulse when the word has been loaded |
| ser_data | output | 1 | Serial data to the tuner |
| ser_clk | output | 1 | Serial clock to the tuner |
| ser_en | output | 1 | Serial enable to the tuner, high across the word |

## Verification
The bench builds the block with CLK_HZ = 2 MHz, which makes each phase four cycles long. With phases that short, every phase of every bit can be timed exactly, and a run of several back-to-back words stays short. It also widens FREQ_W to 30. With the default width the divider count never reaches bit 20. At 30 bits, an input whose count spills into bits 21:20 becomes possible, so the unmasked merge into the control fields can be checked. Other cases covered are a zero frequency, a pair of inputs that straddle a multiple of 400, and start strobes that land both during the divide and during the shift.

// File: rtl/tuner_pkg.sv
package tuner_pkg;

    // Fixed layout of the tuner control word
    localparam int WORD_W  = 24;
    localparam int COUNT_W = 20;

    typedef enum logic [1:0] {
        STEP_100K = 2'd0,
        STEP_50K  = 2'd1,
        STEP_25K  = 2'd2
    } step_sel_e;

    typedef struct packed {
        logic               fm_mode;
        logic               spare;
        step_sel_e          step;
        logic [COUNT_W-1:0] count;
    } ctrl_word_t;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_DIV,
        LD_SEND
    } loader_state_e;

    typedef enum logic [1:0] {
        PH_SETUP,
        PH_HIGH,
        PH_HOLD
    } ser_phase_e;

    // Cycles per serial phase, never below one
    function automatic int phase_cycles(input longint clk_hz, input longint phase_ns);
        longint c;
        c = (clk_hz * phase_ns) / 64'd1_000_000_000;
        return (c < 1) ? 1 : int'(c);
    endfunction

    // Merge the fixed control fields with the count; no masking of the count
    function automatic logic [WORD_W-1:0] build_word(input logic [WORD_W-1:0] count_ext);
        ctrl_word_t w;
        w.fm_mode = 1'b1;
        w.spare   = 1'b0;
        w.step    = STEP_25K;
        w.count   = '0;
        return w | count_ext;
    endfunction

endpackage

// File: rtl/tuner_const_divider.sv
module tuner_const_divider #(
    parameter int N_W     = 25,
    parameter int DIVISOR = 400
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  logic [N_W-1:0] dividend,
    output logic [N_W-1:0] quotient,
    output logic           finished
);

    localparam int R_W   = $clog2(DIVISOR + 1);
    localparam int CNT_W = $clog2(N_W + 1);
    localparam logic [R_W:0] DIV_V = (R_W + 1)'(DIVISOR);

    logic             running;
    logic [CNT_W-1:0] steps_left;
    logic [R_W-1:0]   rem_q;
    logic [N_W-1:0]   quo_q;
    logic [R_W:0]     trial;
    logic             fits;

    assign trial    = {rem_q, quo_q[N_W-1]};
    assign fits     = (trial >= DIV_V);
    assign quotient = quo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            running    <= 1'b0;
            steps_left <= '0;
            rem_q      <= '0;
            quo_q      <= '0;
            finished   <= 1'b0;
        end else begin
            finished <= 1'b0;
            if (go) begin
                running    <= 1'b1;
                steps_left <= CNT_W'(N_W);
                rem_q      <= '0;
                quo_q      <= dividend;
            end else if (running) begin
                rem_q      <= fits ? R_W'(trial - DIV_V) : trial[R_W-1:0];
                quo_q      <= {quo_q[N_W-2:0], fits};
                steps_left <= steps_left - 1'b1;
                if (steps_left == CNT_W'(1)) begin
                    running  <= 1'b0;
                    finished <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tuner_bit_shifter.sv
module tuner_bit_shifter
    import tuner_pkg::*;
#(
    parameter int WORD_LEN  = 24,
    parameter int PHASE_CYC = 100
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic [WORD_LEN-1:0] word,
    output logic                ser_data,
    output logic                ser_clk,
    output logic                ser_en,
    output logic                last
);

    localparam int TMR_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam int IDX_W = $clog2(WORD_LEN);

    logic                active;
    ser_phase_e          phase;
    logic [TMR_W-1:0]    tmr;
    logic [IDX_W-1:0]    idx;
    logic [WORD_LEN-1:0] shreg;
    logic                phase_end;
    logic                final_bit;

    assign phase_end = active && (tmr == TMR_W'(PHASE_CYC - 1));
    assign final_bit = (idx == IDX_W'(WORD_LEN - 1));
    assign last      = phase_end && (phase == PH_HOLD) && final_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            phase    <= PH_SETUP;
            tmr      <= '0;
            idx      <= '0;
            shreg    <= '0;
            ser_data <= 1'b0;
            ser_clk  <= 1'b0;
            ser_en   <= 1'b0;
        end else if (go) begin
            active   <= 1'b1;
            phase    <= PH_SETUP;
            tmr      <= '0;
            idx      <= '0;
            shreg    <= word;
            ser_data <= word[0];
            ser_clk  <= 1'b0;
            ser_en   <= 1'b1;
        end else if (active) begin
            if (!phase_end) begin
                tmr <= tmr + 1'b1;
            end else begin
                tmr <= '0;
                case (phase)
                    PH_SETUP: begin
                        phase   <= PH_HIGH;
                        ser_clk <= 1'b1;
                    end
                    PH_HIGH: begin
                        phase   <= PH_HOLD;
                        ser_clk <= 1'b0;
                    end
                    default: begin
                        phase <= PH_SETUP;
                        if (final_bit) begin
                            active   <= 1'b0;
                            ser_en   <= 1'b0;
                            ser_data <= 1'b0;
                        end else begin
                            idx      <= idx + 1'b1;
                            shreg    <= shreg >> 1;
                            ser_data <= shreg[1];
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/tuner_word_loader.sv
module tuner_word_loader
    import tuner_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int PHASE_NS  = 2000,
    parameter int FREQ_W    = 24,
    parameter int IF_OFFSET = 171200,
    parameter int STEP_DIV  = 400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FREQ_W-1:0] freq,
    output logic              busy,
    output logic              done,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              ser_en
);

    localparam int PHASE_CYC = phase_cycles(longint'(CLK_HZ), longint'(PHASE_NS));
    localparam int SUM_W     = FREQ_W + 1;

    loader_state_e     state, nxt;
    logic [SUM_W-1:0]  sum;
    logic [SUM_W-1:0]  div_quot;
    logic              div_fin;
    logic              div_go;
    logic              ser_go;
    logic              ser_last;
    logic [WORD_W-1:0] ctrl_word;

    assign sum       = SUM_W'(freq) + SUM_W'(IF_OFFSET);
    assign div_go    = (state == LD_IDLE) && start;
    assign ser_go    = (state == LD_DIV) && div_fin;
    assign ctrl_word = build_word(WORD_W'(div_quot));

    always_comb begin
        nxt = state;
        case (state)
            LD_IDLE: if (start)    nxt = LD_DIV;
            LD_DIV:  if (div_fin)  nxt = LD_SEND;
            LD_SEND: if (ser_last) nxt = LD_IDLE;
            default:               nxt = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LD_IDLE;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            busy  <= (nxt != LD_IDLE);
            done  <= (state == LD_SEND) && ser_last;
        end
    end

    tuner_const_divider #(
        .N_W     (SUM_W),
        .DIVISOR (STEP_DIV)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .dividend (sum),
        .quotient (div_quot),
        .finished (div_fin)
    );

    tuner_bit_shifter #(
        .WORD_LEN  (WORD_W),
        .PHASE_CYC (PHASE_CYC)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .go       (ser_go),
        .word     (ctrl_word),
        .ser_data (ser_data),
        .ser_clk  (ser_clk),
        .ser_en   (ser_en),
        .last     (ser_last)
    );

endmodule

// File: rtl/tuner_loader_checks.sv
module tuner_loader_checks #(
    parameter int PHASE_CYC = 100
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic ser_data,
    input logic ser_clk,
    input logic ser_en
);

    int hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) hi_cnt <= 0;
        else     hi_cnt <= ser_clk ? hi_cnt + 1 : 0;
    end

    assert_idle_pins_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ser_en && !ser_clk && !ser_data));

    assert_busy_needs_start_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !ser_en));

    assert_end_done_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_en) |-> done);

    assert_clk_in_en_R6: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> ser_en);

    assert_setup_stable_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk) |-> $stable(ser_data));

    assert_high_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    assert_high_len_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_clk) |-> (hi_cnt == PHASE_CYC));

endmodule

bind tuner_word_loader tuner_loader_checks #(.PHASE_CYC(PHASE_CYC)) u_checks (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .ser_data (ser_data),
    .ser_clk  (ser_clk),
    .ser_en   (ser_en)
);

// File: tb/tuner_word_loader_test.sv
module tuner_word_loader_test;

    localparam int CLK_PERIOD = 10;
    localparam int T_CLK_HZ   = 2_000_000;
    localparam int T_FREQ_W   = 30;
    localparam int P          = 4;     // 2 us at 2 MHz

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                start = 1'b0;
    logic [T_FREQ_W-1:0] freq = '0;
    logic                busy, done, ser_data, ser_clk, ser_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // monitor state
    logic        prev_data = 1'b0, prev_clk = 1'b0, prev_en = 1'b0;
    int          age = 0, hi_len = 0, lo_len = 0;
    logic [23:0] cap = '0;
    int          nbits = 0;
    int          err_r5 = 0, err_r6 = 0, err_r7 = 0, err_r4 = 0;
    int          en_rises = 0, done_cnt = 0;
    bit          tail_ok = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tuner_word_loader #(
        .CLK_HZ (T_CLK_HZ),
        .FREQ_W (T_FREQ_W)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .freq     (freq),
        .busy     (busy),
        .done     (done),
        .ser_data (ser_data),
        .ser_clk  (ser_clk),
        .ser_en   (ser_en)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (ser_data != prev_data) age = 1; else age = age + 1;
            if (ser_clk && !ser_en) err_r6 = err_r6 + 1;
            if (ser_en && !prev_en) begin
                en_rises = en_rises + 1;
                lo_len = 0;
            end
            if (ser_clk && !prev_clk) begin
                if (nbits == 0) begin
                    if (lo_len != P) err_r5 = err_r5 + 1;
                end else if (lo_len != 2*P) begin
                    err_r6 = err_r6 + 1;
                end
                if (age < P + 1) err_r5 = err_r5 + 1;
                if (nbits < 24) cap[nbits] = ser_data;
                else            err_r4 = err_r4 + 1;
                nbits  = nbits + 1;
                hi_len = 1;
            end else if (ser_clk) begin
                hi_len = hi_len + 1;
            end
            if (!ser_clk && prev_clk) begin
                if (hi_len != P) err_r5 = err_r5 + 1;
                if (nbits > 0 && nbits <= 24 && ser_data != cap[nbits-1]) err_r6 = err_r6 + 1;
                lo_len = 1;
            end else if (!ser_clk && ser_en) begin
                lo_len = lo_len + 1;
            end
            if (!ser_en && prev_en) begin
                if (lo_len != P) err_r7 = err_r7 + 1;
                tail_ok = done && !busy && !ser_clk && !ser_data;
            end
            if (done) done_cnt = done_cnt + 1;
        end
        prev_data = ser_data;
        prev_clk  = ser_clk;
        prev_en   = ser_en;
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        cap = '0; nbits = 0;
        err_r4 = 0; err_r5 = 0; err_r6 = 0; err_r7 = 0;
        en_rises = 0; done_cnt = 0; tail_ok = 1'b0;
    endtask

    function automatic logic [23:0] expect_word(input longint f);
        longint q;
        q = (f + 171200) / 400;
        return 24'hA00000 | 24'(q);
    endfunction

    // One word; poke=1 adds ignored start strobes during divide and during shift
    task automatic send_word(input longint f, input bit poke, input string name);
        logic [23:0] exp;
        int wait_cyc;
        exp = expect_word(f);
        clear_mon();
        freq  = T_FREQ_W'(f);
        start = 1'b1;
        tick();
        start = 1'b0;
        chk(busy == 1'b1, "R8", {name, " busy after start"}, busy, 1);
        if (poke) begin
            freq  = T_FREQ_W'(f + 4000);
            start = 1'b1;
            tick();
            start = 1'b0;
            wait_cyc = 0;
            while (!ser_en && wait_cyc < 200) begin tick(); wait_cyc++; end
            repeat (10) tick();
            freq  = T_FREQ_W'(f + 8000);
            start = 1'b1;
            tick();
            start = 1'b0;
        end
        while (done_cnt == 0) tick();
        chk(busy == 1'b0, "R8", {name, " busy low at end"}, busy, 0);
        chk(tail_ok, "R9", {name, " done with pins low"}, tail_ok, 1);
        chk(nbits == 24, "R4", {name, " bit count"}, nbits, 24);
        chk(err_r4 == 0, "R4", {name, " extra bits"}, err_r4, 0);
        chk(cap[19:0] == exp[19:0], "R2", {name, " divider count"}, cap[19:0], exp[19:0]);
        chk(cap[23:20] == exp[23:20], "R3", {name, " control fields"}, cap[23:20], exp[23:20]);
        chk(cap == exp, "R4", {name, " LSB-first word"}, cap, exp);
        chk(err_r5 == 0, "R5", {name, " setup/high timing"}, err_r5, 0);
        chk(err_r6 == 0, "R6", {name, " gap/enable/stability"}, err_r6, 0);
        chk(err_r7 == 0, "R7", {name, " tail before enable low"}, err_r7, 0);
        tick();
        chk(done == 1'b0, "R9", {name, " done one cycle"}, done, 0);
        chk(!ser_en && !ser_clk && !ser_data, "R7", {name, " pins stay low"},
            {ser_en, ser_clk, ser_data}, 0);
        if (poke) begin
            repeat (3*P + 60) tick();
            chk(en_rises == 1, "R10", {name, " no second word"}, en_rises, 1);
            chk(done_cnt == 1, "R10", {name, " single done"}, done_cnt, 1);
            chk(busy == 1'b0, "R10", {name, " idle after ignored start"}, busy, 0);
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) tick();
        chk(!ser_en && !ser_clk && !ser_data, "R1", "pins in reset", {ser_en, ser_clk, ser_data}, 0);
        chk(!busy && !done, "R1", "status in reset", {busy, done}, 0);
        rst = 1'b0;
        tick();
        chk(!ser_en && !ser_clk && !ser_data && !busy && !done, "R1", "after release",
            {ser_en, ser_clk, ser_data, busy, done}, 0);
    endtask

    initial begin
        test_reset();
        send_word(1_569_600, 1'b0, "nominal");             // R2 R3 R4
        send_word(0, 1'b0, "zero");                         // R2 exact multiple
        send_word(1_829_199, 1'b0, "below step");           // R2 remainder 399
        send_word(1_829_200, 1'b0, "at step");              // R2 next count
        send_word(838_689_200, 1'b0, "overflow merge");     // R3 count reaches bit 20
        send_word(1_000_000, 1'b1, "ignored starts");       // R10
        send_word(1_230_123, 1'b0, "back to back");         // R8 restart after done
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150_000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule